// File: doc/BRIEF.md
# Single-Master Address Router with Default Responder

This block sits between one shared bus master and a small set of bus slaves that follow a cycle/strobe/acknowledge handshake. It takes the upper part of the master's word address as a slot number, turns it into a one-hot target choice, and passes cycle and strobe only to the chosen slave. Write-enable, byte lanes, write data and the slave-sized part of the address go to every slave at once. On the way back, the chosen slave's acknowledge and read data are steered to the master. The whole path is combinational, so a slave that answers in the same cycle still completes a transfer in one clock.

If the slot field can hold more values than there are slaves, full decoding adds a built-in default responder. It answers any access to an empty slot at once and returns zero data, so a stray address can never stall the master. A minimal-decode build compares only as many low slot bits as are needed to tell the slaves apart. The comparators get narrower, but the upper slot bits alias and unmatched codes get no answer.

Top module: `wb_addr_router`

## Requirements
- R1: The slot field is master word-address bits [MST_AW-1:SLV_AW]. In full decode, slave i gets cycle only when the field equals i and the master cycle is high.
- R2: Slave i's strobe equals the master strobe ANDed with slave i being chosen. No slave sees a strobe while the master strobe is low.
- R3: Write-enable, byte-select and write data reach the slaves unchanged, whatever the address or the cycle state.
- R4: The slave address output carries master byte-address bits [SLV_AW-1:LOW], where LOW = log2(PORT_W/GRAN_W). The master address port omits those LOW bits.
- R5: The master acknowledge follows the chosen slave's acknowledge. Acknowledges from unchosen slaves are ignored.
- R6: The master read data equals the chosen slave's read data. Data from unchosen slaves is ignored.
- R7: With full decode and fewer slaves than slot codes, an access to an empty slot with cycle and strobe high is acknowledged in the same cycle. It returns all-zero read data and raises no slave's cycle or strobe.
- R8: The default responder stays silent while the master strobe or cycle is low.
- R9: With minimal decode, only the low ceil(log2(NUM_SLV)) slot bits are compared, so higher slot bits alias. Unmatched codes choose nothing, give no acknowledge and return zero data.
- R10: At most one slave sees cycle at any time.
- R11: The byte-select width equals PORT_W/GRAN_W, and both widths are limited to 8, 16, 32 or 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the in-line property checks |
| rst_i | input | 1 | Synchronous active-high reset, disables the checks |
| mst_cyc_i | input | 1 | Master bus cycle |
| mst_stb_i | input | 1 | Master strobe |
| mst_we_i | input | 1 | Master write-enable |
| mst_sel_i | input | PORT_W/GRAN_W | Master byte-lane select |
| mst_adr_i | input | MST_AW-LOW | Master word address (byte bits [MST_AW-1:LOW]) |
| mst_wdat_i | input | PORT_W | Master write data |
| mst_ack_o | output | 1 | Acknowledge to the master |
| mst_rdat_o | output | PORT_W | Read data to the master |
| slv_cyc_o | output | NUM_SLV | Per-slave cycle |
| slv_stb_o | output | NUM_SLV | Per-slave strobe |
| slv_we_o | output | 1 | Shared write-enable to all slaves |
| slv_sel_o | output | PORT_W/GRAN_W | Shared byte-lane select |
| slv_adr_o | output | SLV_AW-LOW | Shared slave word address |
| slv_wdat_o | output | PORT_W | Shared write data |
| slv_ack_i | input | NUM_SLV | Per-slave acknowledge |
| slv_rdat_i | input | NUM_SLV*PORT_W | Per-slave read data, slave i at bits [i*PORT_W +: PORT_W] |

## Verification
The in-line properties check on every cycle that at most one slave holds cycle, that no slave strobe appears without a master strobe, and that a master acknowledge taken from a real slave comes from the chosen one. They also check that a cycle with no slave chosen gets an immediate acknowledge and zero data, but only when the strobe is high. What the properties cannot show is that the right slave is chosen for each slot code, that the address slice and shared signals are correct, and how aliasing behaves under minimal decode. The bench scenarios cover these: they sweep every slot code, mix acknowledges and data from unchosen slaves, and run a second minimal-decode instance against its own reference model.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    typedef enum logic {
        DEC_FULL    = 1'b0,
        DEC_MINIMAL = 1'b1
    } dec_mode_e;

    function automatic int unsigned log2_ceil(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    function automatic bit legal_width(input int unsigned w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

    function automatic bit legal_ratio(input int unsigned port_w, input int unsigned gran_w);
        int unsigned q;
        if (gran_w == 0 || gran_w > port_w) return 1'b0;
        q = port_w / gran_w;
        return (q == 1) || (q == 2) || (q == 4) || (q == 8);
    endfunction

    // Number of low slot bits actually compared
    function automatic int unsigned cmp_bits(input dec_mode_e mode,
                                             input int unsigned nslv,
                                             input int unsigned fld_w);
        int unsigned b;
        if (mode == DEC_FULL) return fld_w;
        b = log2_ceil(nslv);
        if (b < 1) b = 1;
        if (b > fld_w) b = fld_w;
        return b;
    endfunction

    function automatic bit needs_default(input dec_mode_e mode,
                                         input int unsigned nslv,
                                         input int unsigned fld_w);
        return (mode == DEC_FULL) && (nslv < (1 << fld_w));
    endfunction

endpackage

// File: rtl/wbr_slot_decode.sv
module wbr_slot_decode
    import wbr_pkg::*;
#(
    parameter int unsigned NUM_SLV = 3,
    parameter int unsigned FLD_W   = 4,
    parameter int unsigned CMP_W   = 4,
    parameter bit          HAS_DEF = 1'b1,
    localparam int unsigned HIT_W  = NUM_SLV + (HAS_DEF ? 1 : 0)
) (
    input  logic [FLD_W-1:0] slot_i,
    output logic [HIT_W-1:0] hit_o
);

    logic [CMP_W-1:0] key;
    assign key = slot_i[CMP_W-1:0];

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_cmp
        assign hit_o[g] = (key == CMP_W'(g));
    end

    if (HAS_DEF) begin : g_default
        assign hit_o[NUM_SLV] = ~|hit_o[NUM_SLV-1:0];
    end

    if (CMP_W < FLD_W) begin : g_alias
        logic unused_hi;
        assign unused_hi = ^slot_i[FLD_W-1:CMP_W];
    end

endmodule

// File: rtl/wbr_req_gate.sv
module wbr_req_gate #(
    parameter int unsigned NUM_SLV = 3
) (
    input  logic               cyc_i,
    input  logic               stb_i,
    input  logic [NUM_SLV-1:0] pick_i,
    output logic [NUM_SLV-1:0] cyc_o,
    output logic [NUM_SLV-1:0] stb_o
);

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_lane
        assign cyc_o[g] = cyc_i & pick_i[g];
        assign stb_o[g] = stb_i & pick_i[g];
    end

endmodule

// File: rtl/wbr_default_resp.sv
module wbr_default_resp (
    input  logic cyc_i,
    input  logic stb_i,
    input  logic here_i,
    output logic ack_o
);

    assign ack_o = here_i & cyc_i & stb_i;

endmodule

// File: rtl/wbr_resp_merge.sv
module wbr_resp_merge #(
    parameter int unsigned NUM_SLV = 3,
    parameter int unsigned PORT_W  = 32
) (
    input  logic [NUM_SLV-1:0]        pick_i,
    input  logic [NUM_SLV-1:0]        ack_i,
    input  logic [NUM_SLV*PORT_W-1:0] rdat_i,
    input  logic                      def_ack_i,
    output logic                      ack_o,
    output logic [PORT_W-1:0]         rdat_o
);

    always_comb begin
        rdat_o = '0;
        for (int k = 0; k < NUM_SLV; k++) begin
            rdat_o = rdat_o | (rdat_i[k*PORT_W +: PORT_W] & {PORT_W{pick_i[k]}});
        end
        ack_o = def_ack_i | (|(ack_i & pick_i));
    end

endmodule

// File: rtl/wb_addr_router.sv
module wb_addr_router
    import wbr_pkg::*;
#(
    parameter int unsigned NUM_SLV  = 3,
    parameter int unsigned MST_AW   = 16,
    parameter int unsigned SLV_AW   = 12,
    parameter int unsigned PORT_W   = 32,
    parameter int unsigned GRAN_W   = 8,
    parameter dec_mode_e   DEC_MODE = DEC_FULL,
    localparam int unsigned SEL_W   = PORT_W / GRAN_W,
    localparam int unsigned LOW     = log2_ceil(SEL_W),
    localparam int unsigned MA_W    = MST_AW - LOW,
    localparam int unsigned SA_W    = SLV_AW - LOW
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      mst_cyc_i,
    input  logic                      mst_stb_i,
    input  logic                      mst_we_i,
    input  logic [SEL_W-1:0]          mst_sel_i,
    input  logic [MA_W-1:0]           mst_adr_i,
    input  logic [PORT_W-1:0]         mst_wdat_i,
    output logic                      mst_ack_o,
    output logic [PORT_W-1:0]         mst_rdat_o,
    output logic [NUM_SLV-1:0]        slv_cyc_o,
    output logic [NUM_SLV-1:0]        slv_stb_o,
    output logic                      slv_we_o,
    output logic [SEL_W-1:0]          slv_sel_o,
    output logic [SA_W-1:0]           slv_adr_o,
    output logic [PORT_W-1:0]         slv_wdat_o,
    input  logic [NUM_SLV-1:0]        slv_ack_i,
    input  logic [NUM_SLV*PORT_W-1:0] slv_rdat_i
);

    localparam int unsigned FLD_W   = MST_AW - SLV_AW;
    localparam int unsigned CMP_W   = cmp_bits(DEC_MODE, NUM_SLV, FLD_W);
    localparam bit          HAS_DEF = needs_default(DEC_MODE, NUM_SLV, FLD_W);
    localparam int unsigned HIT_W   = NUM_SLV + (HAS_DEF ? 1 : 0);

    // Configuration legality (R11)
    if (!legal_width(PORT_W) || !legal_width(GRAN_W) || !legal_ratio(PORT_W, GRAN_W)) begin : g_bad_width
        initial $fatal(1, "wb_addr_router: illegal port width / granularity");
    end
    if (SLV_AW > MST_AW || FLD_W < 1 || SLV_AW <= LOW || NUM_SLV > (1 << FLD_W)) begin : g_bad_map
        initial $fatal(1, "wb_addr_router: illegal address map");
    end

    logic [FLD_W-1:0]   slot;
    logic [HIT_W-1:0]   hit;
    logic [NUM_SLV-1:0] pick;
    logic               def_ack;

    assign slot = mst_adr_i[MA_W-1 -: FLD_W];

    wbr_slot_decode #(
        .NUM_SLV (NUM_SLV),
        .FLD_W   (FLD_W),
        .CMP_W   (CMP_W),
        .HAS_DEF (HAS_DEF)
    ) u_decode (
        .slot_i (slot),
        .hit_o  (hit)
    );

    assign pick = hit[NUM_SLV-1:0];

    wbr_req_gate #(
        .NUM_SLV (NUM_SLV)
    ) u_gate (
        .cyc_i  (mst_cyc_i),
        .stb_i  (mst_stb_i),
        .pick_i (pick),
        .cyc_o  (slv_cyc_o),
        .stb_o  (slv_stb_o)
    );

    if (HAS_DEF) begin : g_def
        wbr_default_resp u_def (
            .cyc_i  (mst_cyc_i),
            .stb_i  (mst_stb_i),
            .here_i (hit[NUM_SLV]),
            .ack_o  (def_ack)
        );
    end else begin : g_nodef
        assign def_ack = 1'b0;
    end

    wbr_resp_merge #(
        .NUM_SLV (NUM_SLV),
        .PORT_W  (PORT_W)
    ) u_merge (
        .pick_i    (pick),
        .ack_i     (slv_ack_i),
        .rdat_i    (slv_rdat_i),
        .def_ack_i (def_ack),
        .ack_o     (mst_ack_o),
        .rdat_o    (mst_rdat_o)
    );

    // Broadcast path
    assign slv_we_o   = mst_we_i;
    assign slv_sel_o  = mst_sel_i;
    assign slv_wdat_o = mst_wdat_i;
    assign slv_adr_o  = mst_adr_i[SA_W-1:0];

    // In-line checks
    AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(slv_cyc_o)); // R10

    AST_STB_NEEDS_MASTER: assert property (@(posedge clk_i) disable iff (rst_i)
        (|slv_stb_o) |-> mst_stb_i); // R2

    AST_ACK_FROM_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
        (mst_ack_o && (|slv_cyc_o)) |-> (|(slv_ack_i & slv_cyc_o))); // R5

    if (HAS_DEF) begin : g_def_checks
        AST_DEFAULT_ACKS: assert property (@(posedge clk_i) disable iff (rst_i)
            (mst_cyc_i && mst_stb_i && (slv_cyc_o == '0)) |-> mst_ack_o); // R7

        AST_DEFAULT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
            (mst_cyc_i && (slv_cyc_o == '0)) |-> (mst_rdat_o == '0)); // R7

        AST_DEFAULT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
            (mst_cyc_i && !mst_stb_i && (slv_cyc_o == '0)) |-> !mst_ack_o); // R8
    end

endmodule

// File: tb/tb_wb_addr_router.sv
`timescale 1ns/1ps
module tb_wb_addr_router;
    import wbr_pkg::*;

    localparam int NS  = 3;
    localparam int DW  = 32;
    localparam int MAW = 14;   // byte bits [15:2]
    localparam int SAW = 10;   // byte bits [11:2]

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic           cyc, stb, we;
    logic [3:0]     sel;
    logic [MAW-1:0] adr;
    logic [DW-1:0]  wdat;
    logic [NS-1:0]  s_ack;
    logic [NS*DW-1:0] s_rdat;

    logic           f_ack, m_ack;
    logic [DW-1:0]  f_rdat, m_rdat;
    logic [NS-1:0]  f_cyc, f_stb, m_cyc, m_stb;
    logic           f_we, m_we;
    logic [3:0]     f_sel, m_sel;
    logic [SAW-1:0] f_adr, m_adr;
    logic [DW-1:0]  f_wdat, m_wdat;

    wb_addr_router #(.NUM_SLV(NS), .MST_AW(16), .SLV_AW(12), .PORT_W(32), .GRAN_W(8),
                     .DEC_MODE(DEC_FULL)) dut (
        .clk_i(clk), .rst_i(rst),
        .mst_cyc_i(cyc), .mst_stb_i(stb), .mst_we_i(we), .mst_sel_i(sel),
        .mst_adr_i(adr), .mst_wdat_i(wdat), .mst_ack_o(f_ack), .mst_rdat_o(f_rdat),
        .slv_cyc_o(f_cyc), .slv_stb_o(f_stb), .slv_we_o(f_we), .slv_sel_o(f_sel),
        .slv_adr_o(f_adr), .slv_wdat_o(f_wdat), .slv_ack_i(s_ack), .slv_rdat_i(s_rdat));

    wb_addr_router #(.NUM_SLV(NS), .MST_AW(16), .SLV_AW(12), .PORT_W(32), .GRAN_W(8),
                     .DEC_MODE(DEC_MINIMAL)) dut_min (
        .clk_i(clk), .rst_i(rst),
        .mst_cyc_i(cyc), .mst_stb_i(stb), .mst_we_i(we), .mst_sel_i(sel),
        .mst_adr_i(adr), .mst_wdat_i(wdat), .mst_ack_o(m_ack), .mst_rdat_o(m_rdat),
        .slv_cyc_o(m_cyc), .slv_stb_o(m_stb), .slv_we_o(m_we), .slv_sel_o(m_sel),
        .slv_adr_o(m_adr), .slv_wdat_o(m_wdat), .slv_ack_i(s_ack), .slv_rdat_i(s_rdat));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: which slave (or none / default) an address reaches
    function automatic int ref_target(input logic [MAW-1:0] a, input bit minimal);
        int f;
        f = minimal ? int'(a[11:10]) : int'(a[13:10]);
        return (f < NS) ? f : -1;
    endfunction

    task automatic compare_all();
        int  tf, tm;
        logic [NS-1:0] pf, pm;
        logic [DW-1:0] rf, rm;
        logic af, am;
        tf = ref_target(adr, 1'b0);
        tm = ref_target(adr, 1'b1);
        pf = (tf >= 0) ? NS'(1 << tf) : '0;
        pm = (tm >= 0) ? NS'(1 << tm) : '0;
        rf = (tf >= 0) ? s_rdat[tf*DW +: DW] : '0;
        rm = (tm >= 0) ? s_rdat[tm*DW +: DW] : '0;
        af = (tf >= 0) ? s_ack[tf] : (cyc & stb);
        am = (tm >= 0) ? s_ack[tm] : 1'b0;
        // full-decode instance
        chk("R1 slave cycle", 64'(f_cyc), 64'(cyc ? pf : '0));
        chk("R2 slave strobe", 64'(f_stb), 64'(stb ? pf : '0));
        chk("R3 write enable", 64'(f_we), 64'(we));
        chk("R3 byte select", 64'(f_sel), 64'(sel));
        chk("R3 write data", 64'(f_wdat), 64'(wdat));
        chk("R4 slave address", 64'(f_adr), 64'(adr[SAW-1:0]));
        chk("R10 one target", 64'($onehot0(f_cyc)), 64'(1));
        if (tf >= 0) begin
            chk("R5 acknowledge", 64'(f_ack), 64'(af));
            chk("R6 read data", 64'(f_rdat), 64'(rf));
        end else begin
            chk((cyc && stb) ? "R7 default ack" : "R8 default quiet", 64'(f_ack), 64'(af));
            chk("R7 default zero data", 64'(f_rdat), 64'(0));
        end
        // minimal-decode instance
        chk("R9 min cycle", 64'(m_cyc), 64'(cyc ? pm : '0));
        chk("R9 min strobe", 64'(m_stb), 64'(stb ? pm : '0));
        chk("R9 min ack", 64'(m_ack), 64'(am));
        chk("R9 min read data", 64'(m_rdat), 64'(rm));
        chk("R9 min address", 64'(m_adr), 64'(adr[SAW-1:0]));
        chk("R9 min broadcast", 64'({m_we, m_sel, m_wdat}), 64'({we, sel, wdat}));
    endtask

    task automatic drive(input logic c, input logic s, input logic w, input logic [3:0] bs,
                         input logic [MAW-1:0] a, input logic [DW-1:0] d,
                         input logic [NS-1:0] k);
        @(posedge clk);
        #1;
        cyc = c; stb = s; we = w; sel = bs; adr = a; wdat = d; s_ack = k;
        for (int i = 0; i < NS; i++) s_rdat[i*DW +: DW] = 32'hA000_0000 + 32'(i * 32'h1111);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        cyc = 0; stb = 0; we = 0; sel = '0; adr = '0; wdat = '0; s_ack = '0; s_rdat = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // reset / idle state
        chk("R1 idle no slave cycle", 64'(f_cyc), 64'(0));
        chk("R7 idle no ack", 64'(f_ack), 64'(0));
        chk("R11 byte select width", 64'($bits(f_sel)), 64'(4));
        rst = 1'b0;

        // sweep every slot code, reads and writes, all acks asserted
        for (int f = 0; f < 16; f++) begin
            drive(1, 1, 0, 4'hF, {4'(f), 10'h155}, 32'h1234_5678, 3'b111);
            drive(1, 1, 1, 4'h3, {4'(f), 10'h2AA}, 32'hCAFE_0000 | 32'(f), 3'b111);
            drive(1, 0, 1, 4'h1, {4'(f), 10'h001}, 32'h0, 3'b111);   // R8 strobe low
            drive(0, 1, 0, 4'h8, {4'(f), 10'h3FF}, 32'hFFFF_FFFF, 3'b000);
        end
        // only unchosen slaves acknowledge (R5)
        drive(1, 1, 0, 4'hF, {4'd1, 10'h010}, 32'h0, 3'b101);
        drive(1, 1, 0, 4'hF, {4'd2, 10'h020}, 32'h0, 3'b011);
        // unmapped write with all slaves acking (R7): no slave disturbed
        drive(1, 1, 1, 4'hF, {4'd9, 10'h033}, 32'hDEAD_BEEF, 3'b111);
        // minimal decode aliasing (R9): code 5 -> slave 1, code 7 -> nothing
        drive(1, 1, 0, 4'hF, {4'd5, 10'h044}, 32'h0, 3'b010);
        drive(1, 1, 0, 4'hF, {4'd7, 10'h055}, 32'h0, 3'b111);

        // random traffic
        for (int n = 0; n < 1500; n++) begin
            drive(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                  MAW'($urandom), 32'($urandom), NS'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule